// File: doc/BRIEF.md
# Adaptive-Threshold Spike Detector and Window Extractor

The block watches one stream of signed neural samples and flags action potentials. A detection statistic is computed for every accepted sample. It is either the squared amplitude or a three-point energy term. That statistic is compared against a threshold that follows the background noise: a running variance estimate scaled by the square of a programmable multiplier. Because the comparison happens in the squared domain, no square root is needed.

On a detection the block raises a one-cycle pulse. It then keeps collecting samples until it holds a fixed 32-sample window: 8 samples of history from before the trigger, the trigger sample itself, and 23 samples that follow it. The window is sent out as a burst of 32 consecutive words. Each word carries the sample-count timestamp of the trigger, and the final word is flagged. A downstream compressor or sorter thus always receives the whole waveshape together with the time of the event.

Top module: `spike_det`

## Requirements
- R1: After reset, `det_o`, `win_valid_o` and `win_last_o` are low. The sample counter starts at 0, the history reads as zero and the variance estimate equals `VAR_INIT` (16).
- R2: With `mode_i`=0, an accepted sample x triggers when x*x > m*m*v. Here v is the variance estimate before this sample updates it, and m is `mult_i` (3 bits), with values 0 to 2 treated as 3. `det_o` goes high for exactly one cycle, the cycle after the sample is accepted.
- R3: With `mode_i`=1, the trigger condition is p1*p1 - x*p2 > m*m*v, where p1 and p2 are the previous and second-previous accepted samples (0 after reset). A constant input therefore never triggers.
- R4: Every accepted sample updates the estimate to v + ((x*x - v) >>> k), using an arithmetic shift with `k` = `shift_i`. The update is applied after the comparison for that sample. The result is never allowed below `VAR_MIN` (1). Without accepted samples the estimate holds.
- R5: A window holds, in order, the 8 samples accepted before the trigger, the trigger sample, and the next 23 accepted samples. Samples from before the first accepted sample read as 0.
- R6: The first window word appears one cycle after the 23rd post-trigger sample is accepted. The remaining words follow on consecutive cycles, 32 words in all, and `win_last_o` is high on the 32nd word only.
- R7: `win_ts_o` equals the number of samples accepted before the trigger sample, with the first sample numbered 0. It is constant across the burst.
- R8: Detections are ignored from the trigger until the burst ends, and then for a further `dead_i` accepted samples. Samples accepted during the burst do not count toward the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W (10) | Signed sample |
| mode_i | input | 1 | 0 = squared amplitude, 1 = energy operator |
| mult_i | input | MULT_W (3) | Threshold multiplier, 3..7 |
| shift_i | input | SHIFT_W (3) | Smoothing shift k |
| dead_i | input | DEAD_W (8) | Extra lockout in samples |
| det_o | output | 1 | One-cycle detection pulse |
| win_valid_o | output | 1 | Window word valid |
| win_data_o | output | SMP_W (10) | Window sample |
| win_last_o | output | 1 | Final word of window |
| win_ts_o | output | TS_W (32) | Trigger sample index |

## Verification
The detection pulse is due one cycle after the posedge that accepts a sample. Each sample is driven at a falling edge, so `det_o` is read at the next falling edge. The first window word is due one cycle after the posedge that accepts the 23rd post-trigger sample. The bench notes the cycle count at that acceptance and requires word i to arrive exactly i+1 cycles later. Expected values come from a bench model of the requirement arithmetic: the variance recurrence, the clamp on the multiplier and the lockout counted in samples. Only outputs are compared against that model.

// File: rtl/spike_det_pkg.sv
package spike_det_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_POST, ST_EMIT, ST_DEAD} cap_state_e;

  // Multiplier codes below 3 fall back to 3.
  function automatic logic [2:0] mult_eff(input logic [2:0] m);
    return (m < 3'd3) ? 3'd3 : m;
  endfunction
endpackage

// File: rtl/spk_noise_est.sv
module spk_noise_est #(
  parameter int SMP_W    = 10,
  parameter int SHIFT_W  = 3,
  parameter int VAR_INIT = 16,
  parameter int VAR_MIN  = 1,
  localparam int VW      = 2 * SMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] sample_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic [VW-1:0]           var_o
);
  logic [VW-1:0]        var_q, sq;
  logic [SMP_W-1:0]     mag;
  logic signed [VW:0]   diff, step, nxt;

  assign mag  = sample_i[SMP_W-1] ? SMP_W'(-sample_i) : SMP_W'(sample_i);
  assign sq   = VW'(mag) * VW'(mag);
  assign diff = $signed({1'b0, sq}) - $signed({1'b0, var_q});
  assign step = diff >>> shift_i;
  assign nxt  = $signed({1'b0, var_q}) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) var_q <= VW'(VAR_INIT);
    else if (valid_i) begin
      if (nxt < $signed((VW+1)'(VAR_MIN))) var_q <= VW'(VAR_MIN);
      else                                 var_q <= nxt[VW-1:0];
    end
  end

  assign var_o = var_q;

  a_r4_var_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    var_q >= VW'(VAR_MIN));
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(var_q));
endmodule

// File: rtl/spk_stat_cmp.sv
module spk_stat_cmp
  import spike_det_pkg::*;
#(
  parameter int SMP_W  = 10,
  parameter int MULT_W = 3,
  localparam int VW    = 2 * SMP_W,
  localparam int PW    = 2 * SMP_W + 2,
  localparam int CW    = VW + 2 * MULT_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] sample_i,
  input  logic                    mode_i,
  input  logic [MULT_W-1:0]       mult_i,
  input  logic [VW-1:0]           var_i,
  output logic                    hit_o
);
  logic signed [SMP_W-1:0] p1_q, p2_q;
  logic signed [PW-1:0]    xs, p1s, p2s, sq_cur, neo;
  logic [CW-1:0]           thr, m_w;
  logic signed [CW:0]      stat, thr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (valid_i) begin
      p2_q <= p1_q;
      p1_q <= sample_i;
    end
  end

  assign xs     = PW'(sample_i);
  assign p1s    = PW'(p1_q);
  assign p2s    = PW'(p2_q);
  assign sq_cur = xs * xs;
  assign neo    = p1s * p1s - xs * p2s;
  assign m_w    = CW'(mult_eff(mult_i));
  assign thr    = m_w * m_w * CW'(var_i);
  assign thr_s  = $signed({1'b0, thr});
  assign stat   = mode_i ? (CW+1)'(neo) : (CW+1)'(sq_cur);
  assign hit_o  = stat > thr_s;

  a_r3_flat_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && sample_i == p1_q && p1_q == p2_q) |-> !hit_o);
endmodule

// File: rtl/spk_win_cap.sv
module spk_win_cap
  import spike_det_pkg::*;
#(
  parameter int SMP_W  = 10,
  parameter int PRE    = 8,
  parameter int POST   = 24,
  parameter int TS_W   = 32,
  parameter int DEAD_W = 8,
  localparam int WIN   = PRE + POST,
  localparam int AW    = $clog2(2 * WIN),
  localparam int HD    = 1 << AW,
  localparam int PCW   = $clog2(POST),
  localparam int ECW   = $clog2(WIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] sample_i,
  input  logic                    hit_i,
  input  logic [DEAD_W-1:0]       dead_i,
  output logic                    det_o,
  output logic                    win_valid_o,
  output logic signed [SMP_W-1:0] win_data_o,
  output logic                    win_last_o,
  output logic [TS_W-1:0]         win_ts_o
);
  localparam logic [PCW-1:0] POST_END = PCW'(POST - 2);
  localparam logic [ECW-1:0] EMIT_END = ECW'(WIN - 1);

  cap_state_e              state_q;
  logic signed [SMP_W-1:0] hist_q [HD];
  logic [AW-1:0]           wr_ptr_q, rd_ptr_q;
  logic [TS_W-1:0]         ts_q, trig_ts_q;
  logic [PCW-1:0]          post_cnt_q;
  logic [ECW-1:0]          emit_cnt_q;
  logic [DEAD_W-1:0]       dead_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      ts_q        <= '0;
      trig_ts_q   <= '0;
      post_cnt_q  <= '0;
      emit_cnt_q  <= '0;
      dead_cnt_q  <= '0;
      det_o       <= 1'b0;
      win_valid_o <= 1'b0;
      win_data_o  <= '0;
      win_last_o  <= 1'b0;
      for (int i = 0; i < HD; i++) hist_q[i] <= '0;
    end else begin
      det_o       <= 1'b0;
      win_valid_o <= 1'b0;
      win_last_o  <= 1'b0;
      if (valid_i) begin
        hist_q[wr_ptr_q] <= sample_i;
        wr_ptr_q         <= wr_ptr_q + 1'b1;
        ts_q             <= ts_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (valid_i && hit_i) begin
          det_o      <= 1'b1;
          state_q    <= ST_POST;
          post_cnt_q <= '0;
          trig_ts_q  <= ts_q;
          rd_ptr_q   <= wr_ptr_q - AW'(PRE);
        end
        ST_POST: if (valid_i) begin
          if (post_cnt_q == POST_END) begin
            state_q    <= ST_EMIT;
            emit_cnt_q <= '0;
          end else post_cnt_q <= post_cnt_q + 1'b1;
        end
        ST_EMIT: begin
          win_valid_o <= 1'b1;
          win_data_o  <= hist_q[rd_ptr_q];
          win_last_o  <= (emit_cnt_q == EMIT_END);
          rd_ptr_q    <= rd_ptr_q + 1'b1;
          emit_cnt_q  <= emit_cnt_q + 1'b1;
          if (emit_cnt_q == EMIT_END) begin
            state_q    <= (dead_i == '0) ? ST_IDLE : ST_DEAD;
            dead_cnt_q <= '0;
          end
        end
        ST_DEAD: if (valid_i) begin
          if (dead_cnt_q == dead_i - 1'b1) state_q <= ST_IDLE;
          else dead_cnt_q <= dead_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign win_ts_o = trig_ts_q;

  a_r6_last_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_last_o |-> win_valid_o);
  a_r6_burst_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_last_o) |=> win_valid_o);
  a_r7_ts_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_last_o) |=> $stable(win_ts_o));
  a_r8_no_det_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> !win_valid_o);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> !det_o);
endmodule

// File: rtl/spike_det.sv
module spike_det #(
  parameter int SMP_W    = 10,
  parameter int MULT_W   = 3,
  parameter int SHIFT_W  = 3,
  parameter int DEAD_W   = 8,
  parameter int TS_W     = 32,
  parameter int PRE      = 8,
  parameter int POST     = 24,
  parameter int VAR_INIT = 16,
  parameter int VAR_MIN  = 1,
  localparam int VW      = 2 * SMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    mode_i,
  input  logic [MULT_W-1:0]       mult_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic [DEAD_W-1:0]       dead_i,
  output logic                    det_o,
  output logic                    win_valid_o,
  output logic signed [SMP_W-1:0] win_data_o,
  output logic                    win_last_o,
  output logic [TS_W-1:0]         win_ts_o
);
  logic [VW-1:0] var_w;
  logic          hit_w;

  spk_noise_est #(.SMP_W(SMP_W), .SHIFT_W(SHIFT_W), .VAR_INIT(VAR_INIT),
                  .VAR_MIN(VAR_MIN)) u_noise (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(smp_valid_i),
    .sample_i(smp_i), .shift_i(shift_i), .var_o(var_w));

  spk_stat_cmp #(.SMP_W(SMP_W), .MULT_W(MULT_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(smp_valid_i),
    .sample_i(smp_i), .mode_i(mode_i), .mult_i(mult_i),
    .var_i(var_w), .hit_o(hit_w));

  spk_win_cap #(.SMP_W(SMP_W), .PRE(PRE), .POST(POST), .TS_W(TS_W),
                .DEAD_W(DEAD_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(smp_valid_i),
    .sample_i(smp_i), .hit_i(hit_w), .dead_i(dead_i),
    .det_o(det_o), .win_valid_o(win_valid_o), .win_data_o(win_data_o),
    .win_last_o(win_last_o), .win_ts_o(win_ts_o));
endmodule

// File: tb/spike_det_bench.sv
`timescale 1ns/1ps
module spike_det_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [9:0] smp = '0;
  logic              mode = 1'b0;
  logic [2:0]        mult = 3'd3;
  logic [2:0]        kshift = 3'd2;
  logic [7:0]        dead = 8'd0;
  logic              det_o, win_valid_o, win_last_o;
  logic signed [9:0] win_data_o;
  logic [31:0]       win_ts_o;

  spike_det u_spike_det (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_i(smp),
    .mode_i(mode), .mult_i(mult), .shift_i(kshift), .dead_i(dead),
    .det_o(det_o), .win_valid_o(win_valid_o), .win_data_o(win_data_o),
    .win_last_o(win_last_o), .win_ts_o(win_ts_o));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int mvar = 16, p1 = 0, p2 = 0, nsent = 0;
  int ph = 0, post_left = 0, dead_left = 0, trig_idx = 0;
  int hist [0:2047];

  // burst monitor
  int cap_n = 0;
  int cap_d [0:63], cap_t [0:63], cap_c [0:63];
  bit cap_l [0:63];
  always @(negedge clk) if (win_valid_o && cap_n < 64) begin
    cap_d[cap_n] = int'(win_data_o);
    cap_l[cap_n] = win_last_o;
    cap_t[cap_n] = int'(win_ts_o);
    cap_c[cap_n] = cyc;
    cap_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(input int x);
    int m, thr;
    m = (mult < 3) ? 3 : int'(mult);
    thr = m * m * mvar;
    if (mode) return (p1 * p1 - x * p2) > thr;
    return (x * x) > thr;
  endfunction

  task automatic check_window(input int acc);
    repeat (36) @(negedge clk);
    chk(cap_n == 32, "R6 word count", cap_n, 32);
    for (int i = 0; i < 32; i++) begin
      int idx, e;
      idx = trig_idx - 8 + i;
      e = (idx < 0) ? 0 : hist[idx];
      chk(cap_d[i] == e, "R5 window sample", cap_d[i], e);
      chk(cap_l[i] == (i == 31), "R6 last flag", int'(cap_l[i]), int'(i == 31));
      chk(cap_t[i] == trig_idx, "R7 timestamp", cap_t[i], trig_idx);
      chk(cap_c[i] == acc + 1 + i, "R6 word cycle", cap_c[i], acc + 1 + i);
    end
  endtask

  task automatic send(input int x, input string tag);
    bit e;
    int acc, sq, d;
    e = (ph == 0) && model_hit(x);
    @(negedge clk);
    smp_valid = 1'b1;
    smp = 10'(x);
    @(negedge clk);
    smp_valid = 1'b0;
    acc = cyc;
    chk(det_o === e, tag, int'(det_o), int'(e));
    hist[nsent] = x;
    nsent++;
    sq = x * x;
    d = (sq - mvar) >>> kshift;
    mvar = mvar + d;
    if (mvar < 1) mvar = 1;
    p2 = p1;
    p1 = x;
    if (e) begin
      ph = 1; post_left = 23; trig_idx = nsent - 1; cap_n = 0;
    end else if (ph == 1) begin
      post_left--;
      if (post_left == 0) begin
        check_window(acc);
        ph = (dead > 0) ? 2 : 0;
        dead_left = int'(dead);
      end
    end else if (ph == 2) begin
      dead_left--;
      if (dead_left == 0) ph = 0;
    end
  endtask

  task automatic t_reset;
    chk(det_o == 1'b0, "R1 det after reset", int'(det_o), 0);
    chk(win_valid_o == 1'b0, "R1 valid after reset", int'(win_valid_o), 0);
    chk(win_last_o == 1'b0, "R1 last after reset", int'(win_last_o), 0);
  endtask

  // trigger on the third sample: pre-history must read zero
  task automatic t_early;
    mode = 0; mult = 3; kshift = 2; dead = 0;
    send(2, "R2 early quiet");
    send(-1, "R2 early quiet");
    send(50, "R2 early trigger");
    for (int i = 0; i < 23; i++) send(i - 11, "R8 post ignore");
  endtask

  task automatic t_abs;
    int v;
    mode = 0; mult = 3; kshift = 2; dead = 0;
    for (int i = 0; i < 30; i++) send((i % 7) - 3, "R2 noise");
    mult = 3'd1;
    v = 1;
    while (v * v <= mvar) v++;
    send(v, "R2 mult below 3 acts as 3");
    send(-60, "R2 abs negative trigger");
    for (int i = 0; i < 23; i++) send(40 - 4 * i, "R8 post ignore");
    mult = 3'd3;
  endtask

  task automatic t_neo;
    mode = 1; kshift = 2; mult = 3; dead = 0;
    for (int i = 0; i < 8; i++) send(100, "R3 flat input");
    for (int i = 0; i < 24; i++) send(0, "R4 decay");
    kshift = 3'd5;
    send(0, "R3 quiet");
    send(60, "R3 rise");
    send(-60, "R3 energy trigger");
    for (int i = 0; i < 23; i++) send((i % 3) * 7, "R3 post");
  endtask

  task automatic t_lock;
    mode = 0; mult = 3; kshift = 5; dead = 8'd4;
    for (int i = 0; i < 10; i++) send(0, "R2 quiet");
    send(80, "R8 first trigger");
    for (int i = 0; i < 23; i++) send(0, "R8 post");
    send(80, "R8 dead ignore");
    for (int i = 0; i < 3; i++) send(0, "R8 dead");
    send(80, "R8 rearmed trigger");
    for (int i = 0; i < 23; i++) send(i, "R7 post");
    for (int i = 0; i < 4; i++) send(0, "R8 dead");
  endtask

  task automatic t_floor;
    mode = 0; mult = 3; kshift = 0; dead = 0;
    send(0, "R4 floor");
    send(0, "R4 floor");
    send(1, "R4 floor holds threshold");
    send(4, "R4 floor trigger");
    for (int i = 0; i < 23; i++) send(-i, "R5 post");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_early;
    t_abs;
    t_neo;
    t_lock;
    t_floor;
    repeat (5) @(negedge clk);
    summary;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary;
  end
endmodule